// File: doc/BRIEF.md
# Arithmetic and Logic Unit with Status Flags

This block is the execute-stage datapath for register-to-register integer operations. It takes two 32-bit operands, the present value of the destination register, and a 10-bit function selector. It returns a 32-bit result within the same cycle, through combinational logic only. The operations are add, subtract, multiply, multiply-accumulate, the three bitwise logic operations, three shifts, byte reversal, leading-zero count and bit-field extract.

Next to the datapath sits a 4-bit status register. When the flag-enable input is high, the register captures the zero, negative, carry and overflow conditions of the current result on the rising clock edge. Software can also load the flags directly through a separate write port, and this write overrides an update from the datapath in the same cycle. A read port returns the flags zero-extended to 32 bits, which serves a move-from-status operation.

The block has no sequencing of its own, so it has no state machine. Its only stored state is the status register. That register has two ways to change, a software load or a datapath capture, and otherwise it holds its value.

Top module: `alu_status`

## Requirements
- R1: With function 0x001, result is op_a + op_b modulo 2^32. The carry flag is the carry out of bit 31, and the overflow flag is set when both operands have the same sign and the result sign differs from it.
- R2: With function 0x002, result is op_a - op_b, computed as op_a + ~op_b + 1. The carry flag is the carry out of that sum, so it is 1 when there is no borrow. The overflow flag is set when the operand signs differ and the result sign differs from op_a.
- R3: With function 0x003, result is the low 32 bits of op_a * op_b. With function 0x006, result is acc_in + op_a * op_b, kept to its low 32 bits. Both clear the carry and overflow flags.
- R4: Functions 0x007, 0x008 and 0x009 give op_a AND op_b, op_a OR op_b and op_a XOR op_b. Each clears the carry and overflow flags.
- R5: Functions 0x00A (shift left), 0x00B (logical shift right, zero fill) and 0x00C (arithmetic shift right, sign fill) shift op_a by op_b[4:0] only. They clear the carry and overflow flags.
- R6: Function 0x00E returns op_a with its four bytes in reverse order, so byte 0 moves to bits 31:24.
- R7: Function 0x00F returns the number of leading zero bits of op_a. The count is 32 when op_a is zero.
- R8: Function 0x00D returns (op_a >> op_b[4:0]) masked to op_b[9:5] bits, right-aligned and zero-filled. A length field of 0 means 32 bits.
- R9: The flags bus has bit 0 = Z (result is zero), bit 1 = N (result bit 31), bit 2 = C and bit 3 = V. For every recognised function the captured Z and N follow the result.
- R10: The flags change on a rising clock edge only when flag_en is high and the function is recognised. Otherwise they hold their value.
- R11: When sr_wr is high, sr_load is loaded into the flags on the next edge. This takes priority over a flag_en update in the same cycle.
- R12: sr_word always equals the flags zero-extended to 32 bits.
- R13: An unrecognised function code gives a result of zero and leaves the flags unchanged, even with flag_en high.
- R14: An active-low reset clears the flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the status register |
| rst_n | input | 1 | Active-low reset; clears the flags |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand, shift amount or slice descriptor |
| acc_in | input | 32 | Present destination value, used as the addend for multiply-accumulate |
| func | input | 10 | Function selector |
| flag_en | input | 1 | Capture the result flags on this edge |
| sr_wr | input | 1 | Load the flags from sr_load on this edge |
| sr_load | input | 4 | New flag value for a direct load |
| result | output | 32 | Combinational result |
| flags | output | 4 | Status register {V, C, N, Z} |
| sr_word | output | 32 | Flags zero-extended to 32 bits |

## Verification
The hardest case to reach from the ports is the same-cycle collision. A software load of the flags and a datapath capture are both requested on one edge, and the operation has flag values that differ from the loaded pattern. The stimulus arranges this with an addition that sets Z and C while the load carries V and N, so the outcome shows which source won. Arithmetic flag corners are reached with chosen operand pairs: the most negative value minus one, the largest positive value plus one, all ones plus one, and a subtraction that borrows. An unrecognised code and a cycle with flag_en low follow an operation that left non-zero flags, so any unwanted change would show.

// File: rtl/alu_status_pkg.sv
package alu_status_pkg;

    localparam int FN_W = 10;
    localparam int SR_W = 4;

    localparam int FLAG_Z = 0;
    localparam int FLAG_N = 1;
    localparam int FLAG_C = 2;
    localparam int FLAG_V = 3;

    typedef enum logic [FN_W-1:0] {
        FN_ADD   = 10'h001,
        FN_SUB   = 10'h002,
        FN_MUL   = 10'h003,
        FN_MAC   = 10'h006,
        FN_AND   = 10'h007,
        FN_OR    = 10'h008,
        FN_XOR   = 10'h009,
        FN_SHL   = 10'h00A,
        FN_SHRL  = 10'h00B,
        FN_SHRA  = 10'h00C,
        FN_FIELD = 10'h00D,
        FN_REVB  = 10'h00E,
        FN_LZC   = 10'h00F
    } alu_fn_e;

    function automatic logic fn_known(input logic [FN_W-1:0] f);
        case (f)
            FN_ADD, FN_SUB, FN_MUL, FN_MAC, FN_AND, FN_OR, FN_XOR,
            FN_SHL, FN_SHRL, FN_SHRA, FN_FIELD, FN_REVB, FN_LZC: fn_known = 1'b1;
            default: fn_known = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/alu_status_arith.sv
module alu_status_arith
    import alu_status_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [FN_W-1:0]   func,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [DATA_W-1:0] acc_in,
    output logic [DATA_W-1:0] res,
    output logic              carry,
    output logic              ovf,
    output logic              hit
);

    localparam int SUM_W = DATA_W + 1;

    logic              is_sub;
    logic [DATA_W-1:0] b_eff;
    logic [SUM_W-1:0]  sum_ext;
    logic [DATA_W-1:0] prod;
    logic [DATA_W-1:0] mac_sum;
    logic              sign_a;
    logic              sign_b_eff;
    logic              sign_s;

    assign is_sub     = (func == FN_SUB);
    assign b_eff      = is_sub ? ~op_b : op_b;
    assign sum_ext    = {1'b0, op_a} + {1'b0, b_eff} + SUM_W'(is_sub);
    assign prod       = op_a * op_b;
    assign mac_sum    = acc_in + prod;
    assign sign_a     = op_a[DATA_W-1];
    assign sign_b_eff = b_eff[DATA_W-1];
    assign sign_s     = sum_ext[DATA_W-1];

    always_comb begin
        res   = '0;
        carry = 1'b0;
        ovf   = 1'b0;
        hit   = 1'b1;
        case (func)
            FN_ADD, FN_SUB: begin
                res   = sum_ext[DATA_W-1:0];
                carry = sum_ext[DATA_W];
                ovf   = (sign_a == sign_b_eff) && (sign_s != sign_a);
            end
            FN_MUL:  res = prod;
            FN_MAC:  res = mac_sum;
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_status_bits.sv
module alu_status_bits
    import alu_status_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [FN_W-1:0]   func,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic [DATA_W-1:0] res,
    output logic              hit
);

    localparam int SH_W    = $clog2(DATA_W);
    localparam int CNT_W   = SH_W + 1;
    localparam int N_BYTES = DATA_W / 8;

    logic [SH_W-1:0]   shamt;
    logic [SH_W-1:0]   fld_len;
    logic [DATA_W-1:0] fld_shift;
    logic [DATA_W-1:0] fld_mask;
    logic [DATA_W-1:0] rev;
    logic [CNT_W-1:0]  lz_cnt;
    logic              lz_seen;

    assign shamt     = op_b[SH_W-1:0];
    assign fld_len   = op_b[2*SH_W-1:SH_W];
    assign fld_shift = op_a >> shamt;
    assign fld_mask  = (fld_len == '0) ? '1 : ((DATA_W'(1) << fld_len) - DATA_W'(1));

    for (genvar g = 0; g < N_BYTES; g++) begin : g_rev
        assign rev[8*g +: 8] = op_a[8*(N_BYTES-1-g) +: 8];
    end

    always_comb begin
        lz_cnt  = CNT_W'(DATA_W);
        lz_seen = 1'b0;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            if (!lz_seen && op_a[i]) begin
                lz_cnt  = CNT_W'(DATA_W - 1 - i);
                lz_seen = 1'b1;
            end
        end
    end

    always_comb begin
        res = '0;
        hit = 1'b1;
        case (func)
            FN_AND:   res = op_a & op_b;
            FN_OR:    res = op_a | op_b;
            FN_XOR:   res = op_a ^ op_b;
            FN_SHL:   res = op_a << shamt;
            FN_SHRL:  res = op_a >> shamt;
            FN_SHRA:  res = $unsigned($signed(op_a) >>> shamt);
            FN_FIELD: res = fld_shift & fld_mask;
            FN_REVB:  res = rev;
            FN_LZC:   res = DATA_W'(lz_cnt);
            default:  hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_status_sreg.sv
module alu_status_sreg
    import alu_status_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_en,
    input  logic [SR_W-1:0] load_val,
    input  logic            upd_en,
    input  logic [SR_W-1:0] upd_val,
    output logic [SR_W-1:0] sr_q
);

    logic [SR_W-1:0] sr_d;

    always_comb begin
        sr_d = sr_q;
        if (load_en) begin
            sr_d = load_val;
        end else if (upd_en) begin
            sr_d = upd_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else begin
            sr_q <= sr_d;
        end
    end

endmodule

// File: rtl/alu_status.sv
module alu_status
    import alu_status_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [FN_W-1:0]   func,
    input  logic              flag_en,
    input  logic              sr_wr,
    input  logic [SR_W-1:0]   sr_load,
    output logic [DATA_W-1:0] result,
    output logic [SR_W-1:0]   flags,
    output logic [DATA_W-1:0] sr_word
);

    logic [DATA_W-1:0] ar_res;
    logic              ar_c;
    logic              ar_v;
    logic              ar_hit;
    logic [DATA_W-1:0] bt_res;
    logic              bt_hit;
    logic              known;
    logic [SR_W-1:0]   next_flags;

    alu_status_arith #(.DATA_W(DATA_W)) u_arith (
        .func   (func),
        .op_a   (op_a),
        .op_b   (op_b),
        .acc_in (acc_in),
        .res    (ar_res),
        .carry  (ar_c),
        .ovf    (ar_v),
        .hit    (ar_hit)
    );

    alu_status_bits #(.DATA_W(DATA_W)) u_bits (
        .func (func),
        .op_a (op_a),
        .op_b (op_b),
        .res  (bt_res),
        .hit  (bt_hit)
    );

    assign known  = ar_hit | bt_hit;
    assign result = ar_hit ? ar_res : (bt_hit ? bt_res : '0);

    always_comb begin
        next_flags         = '0;
        next_flags[FLAG_Z] = (result == '0);
        next_flags[FLAG_N] = result[DATA_W-1];
        next_flags[FLAG_C] = ar_hit & ar_c;
        next_flags[FLAG_V] = ar_hit & ar_v;
    end

    alu_status_sreg u_sreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (sr_wr),
        .load_val (sr_load),
        .upd_en   (flag_en & known),
        .upd_val  (next_flags),
        .sr_q     (flags)
    );

    assign sr_word = {{(DATA_W-SR_W){1'b0}}, flags};

endmodule

// File: rtl/alu_status_chk.sv
module alu_status_chk
    import alu_status_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [FN_W-1:0]   func,
    input logic              flag_en,
    input logic              sr_wr,
    input logic [SR_W-1:0]   sr_load,
    input logic [DATA_W-1:0] result,
    input logic [SR_W-1:0]   flags,
    input logic [DATA_W-1:0] sr_word
);

    logic fn_logic;
    assign fn_logic = (func == FN_AND) || (func == FN_OR) || (func == FN_XOR) ||
                      (func == FN_SHL) || (func == FN_SHRL) || (func == FN_SHRA);

    // R11
    sr_load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sr_wr |=> (flags == $past(sr_load)));

    // R9
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_en && !sr_wr && fn_known(func)) |=> (flags[FLAG_Z] == ($past(result) == '0)));

    // R9
    neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_en && !sr_wr && fn_known(func)) |=> (flags[FLAG_N] == $past(result[DATA_W-1])));

    // R10
    hold_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_en && !sr_wr) |=> $stable(flags));

    // R13
    unknown_fn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fn_known(func) |-> (result == '0));

    // R13
    unknown_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fn_known(func) && !sr_wr) |=> $stable(flags));

    // R4
    logic_cv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_en && !sr_wr && fn_logic) |=> (flags[FLAG_C] == 1'b0 && flags[FLAG_V] == 1'b0));

    // R12
    sr_word_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sr_word == {{(DATA_W-SR_W){1'b0}}, flags});

endmodule

bind alu_status alu_status_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .func    (func),
    .flag_en (flag_en),
    .sr_wr   (sr_wr),
    .sr_load (sr_load),
    .result  (result),
    .flags   (flags),
    .sr_word (sr_word)
);

// File: tb/alu_status_bench.sv
module alu_status_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [31:0] acc_in = '0;
    logic [9:0]  func = '0;
    logic        flag_en = 1'b0;
    logic        sr_wr = 1'b0;
    logic [3:0]  sr_load = '0;
    logic [31:0] result;
    logic [3:0]  flags;
    logic [31:0] sr_word;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [31:0] res;
        logic [3:0]  fl;
        string       tag;
    } item_t;

    item_t      sb[$];
    logic [3:0] model_fl = 4'h0;

    always #5 clk = ~clk;

    alu_status u_alu_status (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .acc_in(acc_in),
        .func(func), .flag_en(flag_en), .sr_wr(sr_wr), .sr_load(sr_load),
        .result(result), .flags(flags), .sr_word(sr_word)
    );

    task automatic model(input logic [9:0] f, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] d, output logic [31:0] r, output bit c,
                         output bit v, output bit ok);
        logic [63:0] wide;
        int unsigned cnt;
        int unsigned st;
        int unsigned ln;
        r = 0; c = 0; v = 0; ok = 1;
        case (f)
            10'h001: begin
                wide = {32'b0, a} + {32'b0, b};
                r = wide[31:0]; c = wide[32];
                v = (a[31] == b[31]) && (r[31] != a[31]);
            end
            10'h002: begin
                r = a - b; c = (a >= b);
                v = (a[31] != b[31]) && (r[31] != a[31]);
            end
            10'h003: begin wide = {32'b0, a} * {32'b0, b}; r = wide[31:0]; end
            10'h006: begin wide = {32'b0, a} * {32'b0, b}; r = wide[31:0] + d; end
            10'h007: r = a & b;
            10'h008: r = a | b;
            10'h009: r = a ^ b;
            10'h00A: r = a << b[4:0];
            10'h00B: r = a >> b[4:0];
            10'h00C: begin
                r = a >> b[4:0];
                for (int i = 0; i < 32; i++) if (a[31] && i >= 32 - int'(b[4:0])) r[i] = 1'b1;
            end
            10'h00D: begin
                st = b[4:0]; ln = (b[9:5] == 0) ? 32 : b[9:5];
                for (int i = 0; i < 32; i++) if (i < ln && st + i < 32) r[i] = a[st+i];
            end
            10'h00E: r = {a[7:0], a[15:8], a[23:16], a[31:24]};
            10'h00F: begin
                cnt = 0;
                while (cnt < 32 && a[31-cnt] == 1'b0) cnt++;
                r = cnt;
            end
            default: ok = 0;
        endcase
    endtask

    task automatic drive(input logic [9:0] f, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] d, input bit fen, input bit srw,
                         input logic [3:0] srv, input string tag);
        logic [31:0] r;
        bit c, v, ok;
        item_t it;
        @(negedge clk);
        func = f; op_a = a; op_b = b; acc_in = d;
        flag_en = fen; sr_wr = srw; sr_load = srv;
        model(f, a, b, d, r, c, v, ok);
        if (srw) model_fl = srv;
        else if (fen && ok) model_fl = {v, c, r[31], (r == 0)};
        it.res = r; it.fl = model_fl; it.tag = tag;
        sb.push_back(it);
    endtask

    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                it = sb.pop_front();
                checks++;
                if (result !== it.res) begin
                    errors++;
                    $display("FAIL %s result actual %h expected %h", it.tag, result, it.res);
                end
                checks++;
                if (flags !== it.fl) begin
                    errors++;
                    $display("FAIL %s flags actual %h expected %h", it.tag, flags, it.fl);
                end
                checks++;
                if (sr_word !== {28'b0, it.fl}) begin
                    errors++;
                    $display("FAIL R12 sr_word actual %h expected %h", sr_word, {28'b0, it.fl});
                end
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (flags !== 4'h0 || sr_word !== 32'h0) begin
            errors++;
            $display("FAIL R14 reset flags actual %h expected %h", flags, 4'h0);
        end
        // R1 add: wrap to zero with carry, positive overflow
        drive(10'h001, 32'hFFFF_FFFF, 32'h1, 0, 1, 0, 0, "R1 add carry");
        drive(10'h001, 32'h7FFF_FFFF, 32'h1, 0, 1, 0, 0, "R1 add overflow");
        drive(10'h001, 32'd1234, 32'd4321, 0, 1, 0, 0, "R1 add plain");
        // R2 subtract
        drive(10'h002, 32'd5, 32'd5, 0, 1, 0, 0, "R2 sub equal");
        drive(10'h002, 32'd3, 32'd5, 0, 1, 0, 0, "R2 sub borrow");
        drive(10'h002, 32'h8000_0000, 32'h1, 0, 1, 0, 0, "R2 sub overflow");
        // R3 multiply and accumulate
        drive(10'h003, 32'h0001_0001, 32'h0001_0003, 0, 1, 0, 0, "R3 mul");
        drive(10'h006, 32'd7, 32'd9, 32'hFFFF_FFC1, 1, 0, 0, "R3 mac wrap");
        drive(10'h006, 32'hFFFF_FFFF, 32'd2, 32'd100, 1, 0, 0, "R3 mac");
        // R4 logic
        drive(10'h001, 32'h7FFF_FFFF, 32'h1, 0, 1, 0, 0, "R1 set V");
        drive(10'h007, 32'hF0F0_1234, 32'h0FF0_FF00, 0, 1, 0, 0, "R4 and");
        drive(10'h008, 32'h8000_0000, 32'h0000_0001, 0, 1, 0, 0, "R4 or");
        drive(10'h009, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 0, 1, 0, 0, "R4 xor zero");
        // R5 shifts, amount uses low five bits only
        drive(10'h00A, 32'h0000_0003, 32'd33, 0, 1, 0, 0, "R5 shl");
        drive(10'h00B, 32'h8000_0000, 32'd31, 0, 1, 0, 0, "R5 shrl");
        drive(10'h00C, 32'h8000_0010, 32'd4, 0, 1, 0, 0, "R5 shra neg");
        drive(10'h00C, 32'h4000_0000, 32'd62, 0, 1, 0, 0, "R5 shra pos");
        // R6 byte reversal
        drive(10'h00E, 32'h1122_3344, 0, 0, 1, 0, 0, "R6 revb");
        // R7 leading zeros
        drive(10'h00F, 32'h0, 0, 0, 1, 0, 0, "R7 lzc zero");
        drive(10'h00F, 32'h1, 0, 0, 1, 0, 0, "R7 lzc one");
        drive(10'h00F, 32'h8000_0000, 0, 0, 1, 0, 0, "R7 lzc top");
        // R8 field extract
        drive(10'h00D, 32'hDEAD_BEEF, {22'b0, 5'd8, 5'd4}, 0, 1, 0, 0, "R8 field");
        drive(10'h00D, 32'hDEAD_BEEF, 32'h0, 0, 1, 0, 0, "R8 field full");
        drive(10'h00D, 32'hDEAD_BEEF, {22'b0, 5'd16, 5'd24}, 0, 1, 0, 0, "R8 field edge");
        // R9 negative flag from result
        drive(10'h002, 32'd0, 32'd1, 0, 1, 0, 0, "R9 neg");
        // R10 no update without enable
        drive(10'h001, 32'd0, 32'd0, 0, 0, 0, 0, "R10 hold");
        // R13 unknown function, enable high
        drive(10'h3FF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 1, 0, 0, "R13 unknown");
        drive(10'h005, 32'd10, 32'd3, 0, 1, 0, 0, "R13 unknown mod");
        // R11 direct load, and load beats update in the same cycle
        drive(10'h3FF, 0, 0, 0, 0, 1, 4'h5, "R11 load");
        drive(10'h001, 32'hFFFF_FFFF, 32'h1, 0, 1, 1, 4'hA, "R11 priority");
        drive(10'h000, 0, 0, 0, 0, 0, 0, "R10 idle");
        repeat (3) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule